// File: doc/BRIEF.md
# Modular Programmable Clock Divider

This block divides an input clock by any integer from 3 to 2048 for the feedback path of a frequency synthesizer. Division is done by a cascade of divide-by-2/3 cells. Each cell adds at most one input cycle per output period, and the modulus-control signal travels back from the top cell toward the bottom one. The divider is therefore truly modular: every ratio in the range is reachable, with no gaps of the kind a prescaler-and-swallow-counter scheme leaves.

The ratio comes from a control word. Cells above the most significant set bit of the effective ratio are switched off, and their modulus-control line is held active. This extends the ratio range below a power of two, down to 3. The output is a one-cycle pulse per divided period. A new control word is taken only when a period closes, so no period ever has a length between the old and new ratios.

The model is cycle-accurate and synchronous. Each cell advances on an enable that the cell below it produces.

Top module: `mod_divider`

## Requirements
- R1: For a control word value N from 3 to 2^W-1, successive output pulses are exactly N input cycles apart.
- R2: A control word of zero gives a period of 2^W input cycles (2048 at the default W=11).
- R3: Control words 1 and 2 are clamped, and each gives a period of 3 input cycles.
- R4: Every output pulse is high for exactly one input cycle.
- R5: A control word change is sampled only in the cycle a period ends. The period in progress keeps the old ratio, and the following period uses the new one.
- R6: While reset is asserted, the output is low.
- R7: Ratios on both sides of every power-of-two boundary (2^k-1, 2^k, 2^k+1) give their exact periods. The number of active cells changes across these boundaries without a gap or a missing ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low reset |
| div_i | input | W | Ratio control word (0 selects 2^W, 1 and 2 select 3) |
| pulse_o | output | 1 | One-cycle pulse per divided period |

## Verification
A small six-cell configuration is swept in ascending and then descending order through every control word. Each measured period must equal the ratio of the word loaded one period earlier. This separates the ratio arithmetic from the boundary latching, and it crosses every change in active-cell count in both directions. A separate pattern changes the word in the middle of a period. This distinguishes a divider that latches at the period boundary from one that picks up the new word at once. The full-width instance is run at its extremes: 3, the clamped words, 1023 to 1025, 2047, and the zero code.

// File: rtl/moddiv_pkg.sv
package moddiv_pkg;
    // Count inside one 2/3 cell period: 0,1 (divide by 2) or 0,1,2 (divide by 3)
    typedef logic [1:0] cell_cnt_t;
    localparam cell_cnt_t CNT_END2 = 2'd1;
    localparam cell_cnt_t CNT_END3 = 2'd2;
endpackage

// File: rtl/moddiv_cell.sv
module moddiv_cell
    import moddiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,      // one input period of this cell elapsed
    input  logic fin_up_i,  // modulus control from the cell above
    input  logic prog_i,    // ratio bit for this cell
    input  logic act_i,     // cell in use
    output logic en_o,      // enable to the cell above
    output logic fin_o      // modulus control to the cell below
);
    typedef struct packed {
        cell_cnt_t cnt;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     last;

    always_comb begin
        st_d = st_q;
        last = act_i & (st_q.cnt == ((prog_i & fin_up_i) ? CNT_END3 : CNT_END2));
        en_o  = en_i & (~act_i | last);
        fin_o = fin_up_i & (~act_i | last);
        if (!act_i) begin
            st_d.cnt = '0;
        end else if (en_i) begin
            st_d.cnt = last ? cell_cnt_t'(0) : st_q.cnt + cell_cnt_t'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/moddiv_cfg.sv
module moddiv_cfg #(
    parameter int W = 11
) (
    input  logic [W-1:0] code_i,
    output logic [W-1:0] prog_o,
    output logic [W-1:0] act_o
);
    localparam logic [W-1:0] MIN_RATIO = W'(3);

    logic [W-1:0] eff;

    always_comb begin
        eff = (code_i < MIN_RATIO) ? MIN_RATIO : code_i;
        for (int i = 0; i < W; i++) begin
            act_o[i] = (code_i == '0) ? 1'b1 : ((eff >> (i + 1)) != '0);
        end
        prog_o = (code_i == '0) ? '0 : (eff & act_o);
    end
endmodule

// File: rtl/mod_divider.sv
module mod_divider #(
    parameter int W = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] div_i,
    output logic         pulse_o
);
    typedef struct packed {
        logic         run;
        logic         pulse;
        logic [W-1:0] prog;
        logic [W-1:0] act;
    } top_st_t;

    top_st_t      st_d, st_q;
    logic [W-1:0] dec_prog, dec_act;
    logic [W:0]   en;
    logic [W:0]   fin;
    logic         wrap;
    logic [W-1:0] prog_cur, act_cur;

    moddiv_cfg #(.W(W)) u_cfg (
        .code_i (div_i),
        .prog_o (dec_prog),
        .act_o  (dec_act)
    );

    assign en[0]  = st_q.run;
    assign fin[W] = 1'b1;

    for (genvar g = 0; g < W; g++) begin : g_cell
        moddiv_cell u_cell (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en[g]),
            .fin_up_i (fin[g+1]),
            .prog_i   (st_q.prog[g]),
            .act_i    (st_q.act[g]),
            .en_o     (en[g+1]),
            .fin_o    (fin[g])
        );
    end

    assign wrap = en[W] & fin[0];

    always_comb begin
        st_d       = st_q;
        st_d.run   = 1'b1;
        st_d.pulse = wrap;
        if (!st_q.run || wrap) begin
            st_d.prog = dec_prog;
            st_d.act  = dec_act;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pulse_o  = st_q.pulse;
    assign prog_cur = st_q.prog;
    assign act_cur  = st_q.act;
endmodule

// File: rtl/moddiv_chk.sv
module moddiv_chk #(
    parameter int W = 11
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         pulse_i,
    input logic         run_i,
    input logic         wrap_i,
    input logic [W-1:0] prog_i,
    input logic [W-1:0] act_i
);
    logic [W:0] exp_cur, exp_q, gap_q;
    logic       armed_q;

    assign exp_cur = ((W+1)'(1) << $countones(act_i)) + (W+1)'(prog_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            exp_q   <= '0;
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            gap_q <= pulse_i ? (W+1)'(1) : gap_q + (W+1)'(1);
            if (pulse_i) begin
                exp_q   <= exp_cur;
                armed_q <= 1'b1;
            end
        end
    end

    // R1
    period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_i && armed_q |-> gap_q == exp_q);

    // R4
    pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_i |=> !pulse_i);

    // R5
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i && !wrap_i |=> $stable(prog_i) && $stable(act_i));

    // R3
    ratio_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> exp_cur >= (W+1)'(3) && exp_cur <= ((W+1)'(1) << W));
endmodule

bind mod_divider moddiv_chk #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_o),
    .run_i   (st_q.run),
    .wrap_i  (wrap),
    .prog_i  (prog_cur),
    .act_i   (act_cur)
);

// File: tb/mod_divider_bench.sv
`timescale 1ns/1ps
module mod_divider_bench;
    localparam int WS = 6;
    localparam int WL = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WS-1:0] div_s = '0;
    logic [WL-1:0] div_l = '0;
    logic          pulse_s, pulse_l;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    mod_divider #(.W(WS)) u_mod_divider (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div_s), .pulse_o(pulse_s));

    mod_divider #(.W(WL)) u_mod_divider_wide (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div_l), .pulse_o(pulse_l));

    function automatic int ratio(int code, int w);
        if (code == 0) return 1 << w;
        if (code < 3)  return 3;
        return code;
    endfunction

    function automatic string req_of(int code);
        if (code == 0) return "R2";
        if (code < 3)  return "R3";
        return "R1/R7";
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pulse_sel(bit wide);
        return wide ? pulse_l : pulse_s;
    endfunction

    task automatic wait_pulse(bit wide);
        int guard = 0;
        @(negedge clk);
        while (!pulse_sel(wide) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Called at a negedge where the pulse is high; returns cycles to the next pulse.
    task automatic interval(bit wide, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse_sel(wide) && n < 5000);
    endtask

    task automatic step_small(int code, ref int prev);
        int n;
        div_s = WS'(code);
        interval(0, n);
        chk(n == ratio(prev, WS), {req_of(prev), "/R5 small"}, n, ratio(prev, WS));
        prev = code;
    endtask

    task automatic step_wide(int code, ref int prev);
        int n;
        div_l = WL'(code);
        interval(1, n);
        chk(n == ratio(prev, WL), {req_of(prev), "/R5 wide"}, n, ratio(prev, WL));
        prev = code;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int prev_s, prev_l, n, cnt;
        div_s = WS'(5);
        div_l = WL'(3);
        prev_s = 5;
        prev_l = 3;
        // R6: output held low during reset
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(pulse_s == 1'b0 && pulse_l == 1'b0, "R6", int'(pulse_s | pulse_l), 0);
        end
        rst_n = 1'b1;

        // Small instance: ascending then descending sweep of every code
        wait_pulse(0);
        for (int c = 0; c < (1 << WS); c++) step_small(c, prev_s);
        for (int c = (1 << WS) - 1; c >= 0; c--) step_small(c, prev_s);

        // R5: change in the middle of a period
        step_small(40, prev_s);
        cnt = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            cnt++;
        end
        div_s = WS'(5);
        while (!pulse_s && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == 40, "R5 mid-period change", cnt, 40);
        interval(0, n);
        chk(n == 5, "R5 new ratio after boundary", n, 5);

        // R4: pulse width at the smallest ratio
        div_s = WS'(3);
        interval(0, n);
        interval(0, n);
        @(negedge clk);
        chk(pulse_s == 1'b0, "R4 one-cycle pulse", int'(pulse_s), 0);

        // Wide instance extremes
        wait_pulse(1);
        step_wide(2047, prev_l);
        step_wide(0, prev_l);
        step_wide(1024, prev_l);
        step_wide(1023, prev_l);
        step_wide(1025, prev_l);
        step_wide(1, prev_l);
        step_wide(2, prev_l);
        step_wide(512, prev_l);
        step_wide(511, prev_l);
        step_wide(3, prev_l);
        step_wide(3, prev_l);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule